// File: doc/BRIEF.md
# Multi-Channel Compare Timer

This peripheral holds six independent 32-bit up-counters, addressed as channels 1 through 6, behind a plain 32-bit word-addressed read/write bus. Each channel advances on a tick chosen from two clock-enable inputs: a fast system tick and a slow 32 kHz tick. The chosen tick can be taken as it is or divided by two. A channel compares its count with a programmable value and, in the counting modes that use it, records an event when the count reaches that value.

The events of all channels land in one shared pending register. Software clears pending bits by writing ones. A shared enable register picks which pending bits drive the single interrupt line. A channel can stop itself after one event, reload to zero and keep going, or ignore the compare value and run freely. Writing the enable and clear bits together starts the count over from zero in whatever mode that write selects.

Top module: `gp_timer`

## Requirements
- R1: Address map (byte addresses, word aligned). Offset 0x00 holds the interrupt-enable bits. Offset 0x08 returns the pending bits when read and acknowledges them when written. Channel n uses bit n-1 in both. Channel n (1..6) owns the 16 bytes at 0x10*n: control at +0x0, tick select at +0x4, count at +0x8 and compare at +0xC. The count register is read-only, so writes to it are ignored. Any other address reads as 0.
- R2: In the control word, bit 0 is the run enable, bits [5:4] are the mode and bit 1 is a clear strobe. The clear strobe always reads back as 0. All other control bits read 0.
- R3: A control write with bit 1 set loads the count with zero in that cycle, even if a tick arrives in the same cycle. The mode and enable written alongside it take effect at once.
- R4: In the tick-select word, bit 4 picks the source: 0 is the system tick and 1 is the slow tick. Bit 0 picks the divider: 0 counts every selected tick and 1 counts every second selected tick. A clear restarts the divider phase.
- R5: In mode 1 (repeat), the tick that would make the count equal the compare value instead sets the channel's pending bit and returns the count to zero. The channel keeps running.
- R6: In mode 0 (one-shot), the tick that makes the count equal the compare value sets the pending bit and drops the channel's enable bit. The count then stays at the compare value.
- R7: In modes 3 and 2 (free-run), the count ignores the compare value, never sets a pending bit and wraps from all ones to zero.
- R8: While the enable bit is 0, the count holds its value whatever the ticks do.
- R9: Writing the acknowledge register clears each pending bit whose data bit is 1 and leaves bits written with 0 unchanged. If a channel's event falls in the same cycle as the acknowledge of its bit, the bit stays set.
- R10: The interrupt output is high when any channel has both its pending bit and its enable bit set. A pending bit latches even while its enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sys_tick_en | input | 1 | Fast system tick, one-cycle clock enable |
| slow_tick_en | input | 1 | Slow 32 kHz tick, one-cycle clock enable |
| bus_wr | input | 1 | Write strobe for bus_addr and bus_wdata |
| bus_addr | input | 8 | Byte address of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a channel's compare event and a software acknowledge of that same pending bit. The bench provokes it by asserting the tick that completes a repeat period on the very edge where the acknowledge write lands. It then judges that the pending bit and the interrupt stay set while the count returns to zero. The second pair is a clear write and a count step. The bench checks that a clearing control write always leaves a zero count in the next cycle. It also checks that the newly written mode governs every tick that follows, including across a mode change from repeat to free-run.

// File: rtl/gp_timer_pkg.sv
package gp_timer_pkg;

  typedef enum logic [1:0] {
    MODE_ONCE   = 2'd0,
    MODE_RELOAD = 2'd1,
    MODE_FREE2  = 2'd2,
    MODE_FREE   = 2'd3
  } tmr_mode_e;

  // word index inside a channel's 16-byte block (address bits [3:2])
  localparam logic [1:0] WSEL_CTRL = 2'd0;
  localparam logic [1:0] WSEL_TSEL = 2'd1;
  localparam logic [1:0] WSEL_CNT  = 2'd2;
  localparam logic [1:0] WSEL_CMP  = 2'd3;

  // word index inside the shared block at offset 0
  localparam logic [1:0] WSEL_IEN  = 2'd0;
  localparam logic [1:0] WSEL_PEND = 2'd2;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_CLR_BIT  = 1;
  localparam int CTRL_MODE_LSB = 4;
  localparam int TSEL_DIV_BIT  = 0;
  localparam int TSEL_SRC_BIT  = 4;

endpackage

// File: rtl/gp_timer_chan.sv
module gp_timer_chan
  import gp_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_tick,
  input  logic              slow_tick,
  input  logic              wr_ctrl,
  input  logic              wr_tsel,
  input  logic              wr_cmp,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_rd,
  output logic [DATA_W-1:0] tsel_rd,
  output logic [DATA_W-1:0] cnt_rd,
  output logic [DATA_W-1:0] cmp_rd,
  output logic              hit
);

  logic              run_q, run_d;
  tmr_mode_e         mode_q, mode_d;
  logic              src_q, src_d;
  logic              div_q, div_d;
  logic              phase_q, phase_d;
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic [DATA_W-1:0] cmp_q, cmp_d;

  logic              tick_sel;
  logic              step;
  logic              uses_cmp;
  logic [DATA_W-1:0] cnt_inc;

  assign tick_sel = src_q ? slow_tick : sys_tick;
  assign step     = run_q && tick_sel && (!div_q || phase_q);
  assign uses_cmp = (mode_q == MODE_ONCE) || (mode_q == MODE_RELOAD);
  assign cnt_inc  = cnt_q + 1'b1;
  assign hit      = step && uses_cmp && (cnt_inc == cmp_q);

  always_comb begin
    run_d   = run_q;
    mode_d  = mode_q;
    src_d   = src_q;
    div_d   = div_q;
    phase_d = phase_q;
    cnt_d   = cnt_q;
    cmp_d   = cmp_q;

    if (run_q && tick_sel && div_q) begin
      phase_d = ~phase_q;
    end

    if (step) begin
      if (hit && (mode_q == MODE_RELOAD)) begin
        cnt_d = '0;
      end else begin
        cnt_d = cnt_inc;
      end
      if (hit && (mode_q == MODE_ONCE)) begin
        run_d = 1'b0;
      end
    end

    if (wr_ctrl) begin
      run_d  = wdata[CTRL_RUN_BIT];
      mode_d = tmr_mode_e'(wdata[CTRL_MODE_LSB +: 2]);
      if (wdata[CTRL_CLR_BIT]) begin
        cnt_d   = '0;
        phase_d = 1'b0;
      end
    end

    if (wr_tsel) begin
      src_d = wdata[TSEL_SRC_BIT];
      div_d = wdata[TSEL_DIV_BIT];
    end

    if (wr_cmp) begin
      cmp_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      mode_q  <= MODE_ONCE;
      src_q   <= 1'b0;
      div_q   <= 1'b0;
      phase_q <= 1'b0;
      cnt_q   <= '0;
      cmp_q   <= '0;
    end else begin
      run_q   <= run_d;
      mode_q  <= mode_d;
      src_q   <= src_d;
      div_q   <= div_d;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      cmp_q   <= cmp_d;
    end
  end

  assign ctrl_rd = DATA_W'({mode_q, 3'b000, run_q});
  assign tsel_rd = DATA_W'({src_q, 3'b000, div_q});
  assign cnt_rd  = cnt_q;
  assign cmp_rd  = cmp_q;

  assert_clear_zeroes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[CTRL_CLR_BIT]) |=> (cnt_q == '0));

  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_ctrl) |=> $stable(cnt_q));

  assert_free_no_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_FREE || mode_q == MODE_FREE2) |-> !hit);

  assert_free_wraps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !uses_cmp && (&cnt_q) && !wr_ctrl) |=> (cnt_q == '0));

  assert_once_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && (mode_q == MODE_ONCE) && !wr_ctrl) |=> (!run_q && (cnt_q == cmp_q)));

  assert_reload_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && (mode_q == MODE_RELOAD) && !wr_ctrl) |=> (run_q && (cnt_q == '0)));

endmodule

// File: rtl/gp_timer_irq.sv
module gp_timer_irq #(
  parameter int NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] hit,
  input  logic              wr_ien,
  input  logic              wr_ack,
  input  logic [NUM_CH-1:0] wdata,
  output logic [NUM_CH-1:0] ien_q,
  output logic [NUM_CH-1:0] pend_q,
  output logic              irq
);

  logic [NUM_CH-1:0] ien_d;
  logic [NUM_CH-1:0] pend_d;
  logic [NUM_CH-1:0] ack_mask;

  assign ack_mask = wr_ack ? wdata : '0;

  always_comb begin
    ien_d  = wr_ien ? wdata : ien_q;
    pend_d = (pend_q & ~ack_mask) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= '0;
      pend_q <= '0;
    end else begin
      ien_q  <= ien_d;
      pend_q <= pend_d;
    end
  end

  assign irq = |(pend_q & ien_q);

  assert_event_latches_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((pend_q & $past(hit)) == $past(hit)));

  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && ((hit & wdata) == '0)) |=> ((pend_q & $past(wdata)) == '0));

  assert_ack_zero_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && (wdata == '0) && !wr_ien) |=> (pend_q == ($past(pend_q) | $past(hit))));

endmodule

// File: rtl/gp_timer_regmap.sv
module gp_timer_regmap
  import gp_timer_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                          bus_wr,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [NUM_CH-1:0][DATA_W-1:0] ctrl_rd,
  input  logic [NUM_CH-1:0][DATA_W-1:0] tsel_rd,
  input  logic [NUM_CH-1:0][DATA_W-1:0] cnt_rd,
  input  logic [NUM_CH-1:0][DATA_W-1:0] cmp_rd,
  input  logic [NUM_CH-1:0]             ien,
  input  logic [NUM_CH-1:0]             pend,
  output logic [NUM_CH-1:0]             wr_ctrl,
  output logic [NUM_CH-1:0]             wr_tsel,
  output logic [NUM_CH-1:0]             wr_cmp,
  output logic                          wr_ien,
  output logic                          wr_ack,
  output logic [DATA_W-1:0]             rdata
);

  localparam int BLK_W = ADDR_W - 4;

  logic [BLK_W-1:0] blk;
  logic [1:0]       wsel;
  logic             unused_low_addr;

  assign blk             = bus_addr[ADDR_W-1:4];
  assign wsel            = bus_addr[3:2];
  assign unused_low_addr = ^bus_addr[1:0];

  assign wr_ien = bus_wr && (blk == '0) && (wsel == WSEL_IEN);
  assign wr_ack = bus_wr && (blk == '0) && (wsel == WSEL_PEND);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_strobe
    logic sel;
    assign sel        = bus_wr && (blk == BLK_W'(c + 1));
    assign wr_ctrl[c] = sel && (wsel == WSEL_CTRL);
    assign wr_tsel[c] = sel && (wsel == WSEL_TSEL);
    assign wr_cmp[c]  = sel && (wsel == WSEL_CMP);
  end

  always_comb begin
    rdata = '0;
    if (blk == '0) begin
      if (wsel == WSEL_IEN) begin
        rdata = DATA_W'(ien);
      end else if (wsel == WSEL_PEND) begin
        rdata = DATA_W'(pend);
      end
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (blk == BLK_W'(c + 1)) begin
        case (wsel)
          WSEL_CTRL: rdata = ctrl_rd[c];
          WSEL_TSEL: rdata = tsel_rd[c];
          WSEL_CNT:  rdata = cnt_rd[c];
          default:   rdata = cmp_rd[c];
        endcase
      end
    end
  end

endmodule

// File: rtl/gp_timer.sv
module gp_timer #(
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_tick_en,
  input  logic              slow_tick_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  logic [NUM_CH-1:0][DATA_W-1:0] ctrl_rd;
  logic [NUM_CH-1:0][DATA_W-1:0] tsel_rd;
  logic [NUM_CH-1:0][DATA_W-1:0] cnt_rd;
  logic [NUM_CH-1:0][DATA_W-1:0] cmp_rd;
  logic [NUM_CH-1:0]             wr_ctrl;
  logic [NUM_CH-1:0]             wr_tsel;
  logic [NUM_CH-1:0]             wr_cmp;
  logic [NUM_CH-1:0]             hit;
  logic [NUM_CH-1:0]             ien_q;
  logic [NUM_CH-1:0]             pend_q;
  logic                          wr_ien;
  logic                          wr_ack;

  gp_timer_regmap #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regmap (
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .ctrl_rd  (ctrl_rd),
    .tsel_rd  (tsel_rd),
    .cnt_rd   (cnt_rd),
    .cmp_rd   (cmp_rd),
    .ien      (ien_q),
    .pend     (pend_q),
    .wr_ctrl  (wr_ctrl),
    .wr_tsel  (wr_tsel),
    .wr_cmp   (wr_cmp),
    .wr_ien   (wr_ien),
    .wr_ack   (wr_ack),
    .rdata    (bus_rdata)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    gp_timer_chan #(
      .DATA_W (DATA_W)
    ) u_chan (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .sys_tick  (sys_tick_en),
      .slow_tick (slow_tick_en),
      .wr_ctrl   (wr_ctrl[c]),
      .wr_tsel   (wr_tsel[c]),
      .wr_cmp    (wr_cmp[c]),
      .wdata     (bus_wdata),
      .ctrl_rd   (ctrl_rd[c]),
      .tsel_rd   (tsel_rd[c]),
      .cnt_rd    (cnt_rd[c]),
      .cmp_rd    (cmp_rd[c]),
      .hit       (hit[c])
    );
  end

  gp_timer_irq #(
    .NUM_CH (NUM_CH)
  ) u_irq (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .hit    (hit),
    .wr_ien (wr_ien),
    .wr_ack (wr_ack),
    .wdata  (bus_wdata[NUM_CH-1:0]),
    .ien_q  (ien_q),
    .pend_q (pend_q),
    .irq    (irq)
  );

  assert_write_single_target_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({wr_ctrl, wr_tsel, wr_cmp, wr_ien, wr_ack}));

  assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq |-> ((pend_q & ien_q) != '0));

endmodule

// File: tb/gp_timer_tb_top.sv
`timescale 1ns/1ps
module gp_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sys_tick_en;
  logic        slow_tick_en;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  gp_timer dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sys_tick_en  (sys_tick_en),
    .slow_tick_en (slow_tick_en),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .irq          (irq)
  );

  function automatic logic [7:0] reg_addr(input int ch, input int word);
    return 8'((ch * 16) + (word * 4));
  endfunction

  function automatic logic [31:0] exp_repeat_cnt(input int n, input int cmp);
    return 32'(n % cmp);
  endfunction

  function automatic logic exp_repeat_pend(input int n, input int cmp);
    return n >= cmp;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic ticks(input bit slow, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (slow) slow_tick_en = 1'b1;
      else      sys_tick_en  = 1'b1;
    end
    @(negedge clk);
    sys_tick_en  = 1'b0;
    slow_tick_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int unused_seed;
    unused_seed = $urandom(1234);
    rst_n = 1'b0; sys_tick_en = 1'b0; slow_tick_en = 1'b0;
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    rd(8'h00, v); check("R1 reset enable", v, 0);
    rd(8'h08, v); check("R1 reset pending", v, 0);
    rd(reg_addr(1, 2), v); check("R1 reset count", v, 0);
    check("R10 reset irq", 32'(irq), 0);

    // channel 1 repeat, compare 5
    wr(reg_addr(1, 1), 32'h0);
    wr(reg_addr(1, 3), 32'd5);
    wr(8'h00, 32'h1);
    wr(reg_addr(1, 0), 32'h13);
    rd(reg_addr(1, 0), v); check("R2 clear reads 0", v, 32'h11);
    ticks(0, 4);
    rd(reg_addr(1, 2), v); check("R5 count before match", v, 4);
    rd(8'h08, v); check("R5 no pending yet", v, 0);
    ticks(0, 1);
    rd(reg_addr(1, 2), v); check("R5 reload to zero", v, 0);
    rd(8'h08, v); check("R5 pending set", v, 1);
    check("R10 irq on enabled pending", 32'(irq), 1);
    ticks(0, 7);
    rd(reg_addr(1, 2), v); check("R5 keeps running", v, 2);

    // acknowledge
    wr(8'h08, 32'h0);
    rd(8'h08, v); check("R9 ack zero keeps", v, 1);
    wr(8'h08, 32'h1);
    rd(8'h08, v); check("R9 ack one clears", v, 0);
    check("R10 irq drops", 32'(irq), 0);

    // restart in free-run
    wr(reg_addr(1, 0), 32'h33);
    rd(reg_addr(1, 2), v); check("R3 restart zero", v, 0);
    rd(reg_addr(1, 0), v); check("R2 mode readback", v, 32'h31);
    ticks(0, 9);
    rd(reg_addr(1, 2), v); check("R7 free-run passes compare", v, 9);
    rd(8'h08, v); check("R7 no pending in free-run", v, 0);

    // disable freezes
    wr(reg_addr(1, 0), 32'h30);
    ticks(0, 5);
    rd(reg_addr(1, 2), v); check("R8 frozen", v, 9);

    // mode 2 also free-runs
    wr(reg_addr(1, 3), 32'd2);
    wr(reg_addr(1, 0), 32'h23);
    ticks(0, 4);
    rd(reg_addr(1, 2), v); check("R7 mode 2 free-run", v, 4);
    rd(8'h08, v); check("R7 mode 2 no pending", v, 0);
    wr(reg_addr(1, 0), 32'h0);

    // channel 2 one-shot, compare 3, interrupt not enabled
    wr(reg_addr(2, 3), 32'd3);
    wr(reg_addr(2, 0), 32'h03);
    ticks(0, 3);
    rd(reg_addr(2, 2), v); check("R6 count at compare", v, 3);
    rd(reg_addr(2, 0), v); check("R6 enable dropped", v, 0);
    rd(8'h08, v); check("R10 pending latched while masked", v, 2);
    check("R10 irq masked", 32'(irq), 0);
    ticks(0, 4);
    rd(reg_addr(2, 2), v); check("R6 stays stopped", v, 3);
    wr(8'h00, 32'h3);
    check("R10 irq after enable", 32'(irq), 1);
    wr(8'h08, 32'h3F);
    rd(8'h08, v); check("R9 ack all", v, 0);

    // channel 3 divide by two
    wr(reg_addr(3, 1), 32'h1);
    wr(reg_addr(3, 3), 32'd100);
    wr(reg_addr(3, 0), 32'h33);
    ticks(0, 7);
    rd(reg_addr(3, 2), v); check("R4 divide by two", v, 3);

    // channel 4 slow source
    wr(reg_addr(4, 1), 32'h10);
    wr(reg_addr(4, 3), 32'd100);
    wr(reg_addr(4, 0), 32'h33);
    ticks(0, 5);
    rd(reg_addr(4, 2), v); check("R4 slow ignores system tick", v, 0);
    ticks(1, 4);
    rd(reg_addr(4, 2), v); check("R4 slow tick counts", v, 4);
    rd(reg_addr(4, 1), v); check("R4 select readback", v, 32'h10);
    wr(reg_addr(4, 2), 32'h1234);
    rd(reg_addr(4, 2), v); check("R1 count write ignored", v, 4);
    rd(8'h04, v); check("R1 unmapped reads 0", v, 0);
    rd(8'h70, v); check("R1 channel 7 absent", v, 0);
    wr(reg_addr(3, 0), 32'h0);
    wr(reg_addr(4, 0), 32'h0);

    // channel 5: event and acknowledge in the same cycle
    wr(8'h00, 32'h10);
    wr(reg_addr(5, 3), 32'd4);
    wr(reg_addr(5, 0), 32'h13);
    ticks(0, 4);
    rd(8'h08, v); check("R5 channel 5 pending", v, 32'h10);
    ticks(0, 3);
    @(negedge clk);
    sys_tick_en = 1'b1; bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'h10;
    @(negedge clk);
    sys_tick_en = 1'b0; bus_wr = 1'b0;
    rd(8'h08, v); check("R9 event beats ack", v, 32'h10);
    check("R10 irq held", 32'(irq), 1);
    rd(reg_addr(5, 2), v); check("R5 zero after collision", v, 0);
    wr(8'h08, 32'h10);
    rd(8'h08, v); check("R9 later ack clears", v, 0);
    wr(reg_addr(5, 0), 32'h0);

    // channel 6 random repeat periods
    for (int it = 0; it < 8; it++) begin
      int cmp;
      int n;
      cmp = 1 + int'($urandom_range(8));
      n   = int'($urandom_range(20));
      wr(reg_addr(6, 3), 32'(cmp));
      wr(8'h08, 32'h20);
      wr(reg_addr(6, 0), 32'h13);
      ticks(0, n);
      rd(reg_addr(6, 2), v); check("R5 random count", v, exp_repeat_cnt(n, cmp));
      rd(8'h08, v); check("R5 random pending", 32'(v[5]), 32'(exp_repeat_pend(n, cmp)));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule